// File: doc/BRIEF.md
# Programmable Six-Tap Clock Prescaler

This block turns the system clock into six timebase taps for a group of counter submodules. Each tap is a single-cycle clock-enable pulse in the system clock domain, so the counters stay fully synchronous and no derived clock is ever built. A first stage divides the clock by two or by three. A binary counter then steps once per first-stage pulse and yields taps two to five. The sixth tap adds a further division of 2, 4, 8 or 16 on top of tap five.

Software programs the block through a small 16-bit register. The register holds a run flag, the two-or-three select for the first stage, and a two-bit select for the ratio of the sixth tap. Clearing the run flag holds both counters at zero, so that several counter submodules can be armed and then started in step. The first-stage ratio may be changed while the prescaler runs. When it changes, the first stage restarts its count cleanly and the binary chain keeps its position.

Top module: `tick_prescaler`

## Requirements
- R1: Control register fields: bit 3 is the run flag, bit 2 selects a first-stage ratio of 3 (1) or 2 (0), and bits 1:0 are the sixth-tap select. Bits 15:4 ignore writes and always read as zero.
- R2: After reset all control bits are 0, `rdata` is 0 and no bit of `tick_o` pulses.
- R3: While the run flag is 0, `tick_o` stays all zero and writes to the other fields produce no pulse.
- R4: With the first-stage select at 0, `tick_o[0]` to `tick_o[4]` pulse once every 2, 4, 8, 16 and 32 clocks.
- R5: With the first-stage select at 1, `tick_o[0]` to `tick_o[4]` pulse once every 3, 6, 12, 24 and 48 clocks.
- R6: `tick_o[5]` pulses once every 64, 128, 256 or 512 clocks for select values 0 to 3 when the first-stage select is 0, and once every 96, 192, 384 or 768 clocks when it is 1.
- R7: When a write sets the run flag from 0, counting starts in the clock after the write. A tap of period P first pulses in the P-th clock of that count.
- R8: Every tap pulse lasts one clock. A pulse on `tick_o[k]` always coincides with a pulse on `tick_o[k-1]`.
- R9: A write that changes the first-stage select while running restarts the first stage. The next `tick_o[0]` pulse comes exactly the new ratio of clocks after the write, with no shortened or doubled pulse. The binary chain keeps its count.
- R10: A read (`rd_en` high) returns the register in `rdata` one clock later. A read in the same clock as a write returns the value from before the write. Otherwise `rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control register |
| rd_en | input | 1 | Read strobe for the control register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| tick_o | output | 6 | Tap enable pulses; bit k is tap k+1 |

## Verification
A register write that changes the first-stage ratio can land in the same clock as a first-stage pulse. The bench provokes this by waiting until its model predicts a `tick_o[0]` pulse and then issuing the toggling write in exactly that clock. The pulse in that clock must still appear, and the chain must advance once. The following `tick_o[0]` pulse must arrive exactly the new ratio of clocks later. A read issued together with a write checks the same kind of overlap on the register port, since it must return the old contents.

// File: rtl/tick_prescaler_pkg.sv
package tick_prescaler_pkg;

  // Field positions inside the control word (software-visible layout)
  localparam int RUN_POS = 3;
  localparam int DIV_POS = 2;
  localparam int SEL_POS = 0;
  localparam int CFG_W   = 4;

  typedef struct packed {
    logic       run;
    logic       div3;
    logic [1:0] sel;
  } psc_cfg_t;

  // Terminal count of the first stage: ratio minus one
  function automatic logic [1:0] stage_last(input logic div3);
    return div3 ? 2'd2 : 2'd1;
  endfunction

  // Mask of the n low bits, n up to 31
  function automatic logic [31:0] low_ones(input int unsigned n);
    return (32'd1 << n) - 32'd1;
  endfunction

  // Number of chain bits that must be all ones for the sixth tap
  function automatic int unsigned last_tap_bits(input int unsigned num_bin,
                                                input logic [1:0] sel);
    return num_bin + 1 + int'(sel);
  endfunction

endpackage

// File: rtl/psc_ctrl_regs.sv
module psc_ctrl_regs
  import tick_prescaler_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output psc_cfg_t          cfg,
  output logic              restart
);

  localparam int RSV_W = DATA_W - CFG_W;

  psc_cfg_t          cfg_q;
  psc_cfg_t          cfg_wr;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    cfg_wr.run  = wdata[RUN_POS];
    cfg_wr.div3 = wdata[DIV_POS];
    cfg_wr.sel  = wdata[SEL_POS +: 2];
  end

  assign rd_word = {{RSV_W{1'b0}}, cfg_q};

  // first-stage ratio change on a running prescaler
  assign restart = wr_en & cfg_q.run & (cfg_wr.div3 != cfg_q.div3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (rd_en) rdata_q <= rd_word;
      if (wr_en) cfg_q <= cfg_wr;
    end
  end

  assign rdata = rdata_q;
  assign cfg   = cfg_q;

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:CFG_W] == '0);  // R1

  AST_READ_OLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rdata[CFG_W-1:0] == $past(cfg_q));  // R10

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));  // R10

endmodule

// File: rtl/psc_first_stage.sv
module psc_first_stage
  import tick_prescaler_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic div3,
  input  logic restart,
  output logic stage_tick
);

  logic [1:0] cnt_q;
  logic [1:0] cnt_d;
  logic [1:0] last;
  logic       at_end;

  assign last   = stage_last(div3);
  assign at_end = (cnt_q == last);

  always_comb begin
    if (!run || restart) cnt_d = 2'd0;
    else if (at_end)     cnt_d = 2'd0;
    else                 cnt_d = cnt_q + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= 2'd0;
    else        cnt_q <= cnt_d;
  end

  assign stage_tick = run & at_end;

  AST_HELD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == 2'd0);  // R3

  AST_NO_DOUBLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stage_tick |=> !stage_tick);  // R8

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == 2'd0);  // R9

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 2'd2);  // R5

endmodule

// File: rtl/psc_tap_chain.sv
module psc_tap_chain
  import tick_prescaler_pkg::*;
#(
  parameter int NUM_BIN = 4,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               stage_tick,
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_BIN-1:0] bin_taps,
  output logic               last_tap
);

  localparam int CHAIN_W = NUM_BIN + (1 << SEL_W);

  logic [CHAIN_W-1:0] cnt_q;
  logic [31:0]        last_mask_full;
  logic [CHAIN_W-1:0] last_mask;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (stage_tick) cnt_q <= cnt_q + 1'b1;
  end

  genvar j;
  generate
    for (j = 0; j < NUM_BIN; j++) begin : g_bin
      assign bin_taps[j] = stage_tick & (&cnt_q[j:0]);
      if (j == 0) begin : g_first
        AST_NEST_ON_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
          bin_taps[j] |-> stage_tick);  // R8
      end else begin : g_next
        AST_NEST_ON_FASTER: assert property (@(posedge clk) disable iff (!rst_n)
          bin_taps[j] |-> bin_taps[j-1]);  // R8
      end
    end
  endgenerate

  assign last_mask_full = low_ones(last_tap_bits(NUM_BIN, 2'(sel)));
  assign last_mask      = last_mask_full[CHAIN_W-1:0];
  assign last_tap       = stage_tick & ((cnt_q & last_mask) == last_mask);

  AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run && stage_tick |=> cnt_q == $past(cnt_q) + 1'b1);  // R4

  AST_LAST_ON_SLOWEST_BIN: assert property (@(posedge clk) disable iff (!rst_n)
    last_tap |-> bin_taps[NUM_BIN-1]);  // R6

endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import tick_prescaler_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_BIN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_BIN+1:0]   tick_o
);

  localparam int NUM_TAPS = NUM_BIN + 2;

  psc_cfg_t           cfg;
  logic               restart;
  logic               stage_tick;
  logic [NUM_BIN-1:0] bin_taps;
  logic               last_tap;

  psc_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wdata   (wdata),
    .rdata   (rdata),
    .cfg     (cfg),
    .restart (restart)
  );

  psc_first_stage u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (cfg.run),
    .div3       (cfg.div3),
    .restart    (restart),
    .stage_tick (stage_tick)
  );

  psc_tap_chain #(.NUM_BIN(NUM_BIN), .SEL_W(2)) u_chain (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (cfg.run),
    .stage_tick (stage_tick),
    .sel        (cfg.sel),
    .bin_taps   (bin_taps),
    .last_tap   (last_tap)
  );

  assign tick_o = {last_tap, bin_taps, stage_tick};

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.run |-> tick_o == '0);  // R3

  AST_RUN_START_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg.run) |-> tick_o == '0);  // R7

  initial begin
    if (NUM_TAPS != $bits(tick_o)) $error("tap count mismatch");
  end

endmodule

// File: tb/tick_prescaler_tb.sv
`timescale 1ns/1ps
module tick_prescaler_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [5:0]  tick_o;

  always #4 clk = ~clk;

  tick_prescaler u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .tick_o(tick_o)
  );

  int total = 0;
  int bad = 0;
  string phase = "R2";
  bit finished = 0;

  // behavioural reference state
  int m_run = 0, m_div = 0, m_sel = 0;
  int m_c1 = 0, m_chain = 0;
  logic [15:0] m_rdata = '0;

  function automatic int ratio1();
    return (m_div != 0) ? 3 : 2;
  endfunction

  function automatic bit m_s1();
    return (m_run != 0) && ((m_c1 + 1) % ratio1() == 0);
  endfunction

  function automatic logic [5:0] exp_ticks();
    logic [5:0] t = '0;
    if (m_s1()) begin
      for (int k = 0; k < 5; k++)
        t[k] = ((m_chain + 1) % (1 << k) == 0);
      t[5] = ((m_chain + 1) % (1 << (5 + m_sel)) == 0);
    end
    return t;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compare this cycle, drive the next edge, advance the model
  task automatic step(input logic we, input logic re, input logic [15:0] wd);
    bit s1;
    check(phase, {10'd0, tick_o}, {10'd0, exp_ticks()});
    check("R10", rdata, m_rdata);
    wr_en = we; rd_en = re; wdata = wd;
    s1 = m_s1();
    if (re) m_rdata = 16'(m_run * 8 + m_div * 4 + m_sel);
    if (m_run == 0) begin
      m_c1 = 0; m_chain = 0;
    end else begin
      if (s1) m_chain = (m_chain + 1) % 256;
      if (we && (int'(wd[2]) != m_div)) m_c1 = 0;
      else if (s1) m_c1 = 0;
      else m_c1++;
    end
    if (we) begin
      m_run = int'(wd[3]); m_div = int'(wd[2]); m_sel = int'(wd[1:0]);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h0);
  endtask

  task automatic wr(input logic [15:0] v);
    step(1'b1, 1'b0, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: reset state
    phase = "R2";
    check("R2", rdata, 16'h0);
    check("R2", {10'd0, tick_o}, 16'h0);
    step(1'b0, 1'b1, 16'h0);
    idle(10);

    // R3: configuration with run cleared gives no pulses
    phase = "R3";
    wr(16'h0007); idle(200);
    wr(16'h0003); idle(200);

    // R4 and R7: ratio 2 from a clean start
    phase = "R7";
    wr(16'h0008); idle(80);
    phase = "R4";
    idle(500);

    // R6: sixth tap, both first-stage ratios, all selects
    phase = "R6";
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 4; s++) begin
        wr(16'h0000); idle(3);
        wr(16'(8 + d * 4 + s));
        idle((d != 0 ? 768 : 512) * 2 + 20);
      end

    // R5: ratio 3
    phase = "R5";
    wr(16'h0000); idle(2);
    wr(16'h000C); idle(400);

    // R9: ratio change on arbitrary cycles and on a first-stage pulse
    phase = "R9";
    for (int i = 0; i < 12; i++) begin
      idle(i % 5 + 1);
      wr(16'(8 + ((m_div != 0) ? 0 : 4) + m_sel));
    end
    for (int i = 0; i < 8; i++) begin
      while (!m_s1()) idle(1);
      wr(16'(8 + ((m_div != 0) ? 0 : 4) + m_sel));
      idle(7);
    end
    idle(300);

    // R1 and R10: reserved bits, read together with write
    phase = "R1";
    step(1'b1, 1'b1, 16'hFFF5);
    step(1'b0, 1'b1, 16'h0);
    check("R1", rdata, 16'h0005);
    step(1'b1, 1'b1, 16'hA5A2);
    check("R10", rdata, 16'h0005);
    idle(5);
    step(1'b0, 1'b1, 16'h0);
    check("R1", rdata, 16'h0002);
    idle(4);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule